// File: doc/BRIEF.md
# Instruction Slot Framing Decoder

The block sits between instruction fetch and issue. It reads aligned 32-bit fetch words, one slot at a time. Each slot holds either one long instruction or a pair of short ones. The block turns the slot into issue packets, each carrying one or two instruction payloads, their addresses and a parallel flag. It also keeps the program counter, including the case where a jump enters a slot at its right halfword. It reports the address that follows the packet currently shown.

Bit 31 of a slot marks a long instruction. When bit 31 is clear, the slot holds two short instructions with 15-bit payloads. The left one sits in bits 30:16 at the lower address and executes first. Bit 15 asks for the pair to issue together. A pair issues together only if both halves meet the pipe-class rule. The left half must be able to run in the first (O) pipe and the right half in the second (S) pipe. A pair that asks for parallel issue but breaks the rule is flagged and then issued one instruction at a time; nothing is dropped. The consumer takes packets through a valid/ready handshake, and the slot stays held until every packet taken from it has been accepted.

Top module: `slot_frame_dec`

## Requirements
- R1: After reset no packet is valid, fetch is ready, and the fetch address is RESET_PC with bits 1:0 cleared.
- R2: For a slot with bit 31 set, entered at an aligned PC, the block shows one packet with the long flag set, lane A payload equal to bits 30:0, lane A address equal to PC, lane B invalid and the parallel flag clear; the following fetch is at PC+4.
- R3: For a slot with bits 31 and 15 clear, the block shows two packets in order: bits 30:16 at PC, then bits 14:0 at PC+2, each in lane A (zero-extended) with the parallel flag clear.
- R4: A slot with bit 31 clear and bit 15 set, whose halves pass the class rule, gives a single packet. Lane A holds bits 30:16 at PC, lane B is valid with bits 14:0 at PC+2, the parallel flag is set and the following fetch is at PC+4.
- R5: A short payload's class is PIPE_MAP[2k+1:2k], where k is payload bits 14:11. Class bit 0 means the instruction may use the O pipe and class bit 1 means it may use the S pipe. A pair passes only when the left class has bit 0 set and the right class has bit 1 set.
- R6: A slot that asks for parallel issue but fails the class rule raises illegal_pair_o together with its left packet. It is then issued as in R3, with the parallel flag clear on both packets.
- R7: When the PC has bit 1 set, the fetch address is the PC with bits 1:0 cleared. The block shows one packet with bits 14:0 of the fetched word, whatever bits 31 and 15 hold, at address PC. The PC then advances by 2.
- R8: While a packet is valid and not accepted, it stays unchanged, and the second packet of a pair is not shown before the first is accepted.
- R9: A redirect loads the PC from redirect_pc_i with bit 0 cleared and drops any held slot; in the next cycle no packet is valid and fetch is ready.
- R10: While a packet is valid, next_pc_o equals lane A's address plus 4 for a long or parallel packet and plus 2 for any other packet.
- R11: Fetch is ready only while no slot is held. A word is captured when fetch is ready and fetch_valid_i is high, and its first packet is valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| redirect_i | input | 1 | Load a new PC and drop the held slot |
| redirect_pc_i | input | ADDR_W | New PC |
| fetch_addr_o | output | ADDR_W | Aligned address of the slot to fetch |
| fetch_ready_o | output | 1 | Block can take a fetch word |
| fetch_valid_i | input | 1 | Fetch word present |
| fetch_data_i | input | 32 | Fetched slot |
| out_valid_o | output | 1 | Packet valid |
| out_ready_i | input | 1 | Consumer accepts packet |
| out_long_o | output | 1 | Lane A is a long instruction |
| out_par_o | output | 1 | Both lanes issue together |
| out_a_insn_o | output | 31 | Lane A payload, short payloads zero-extended |
| out_a_addr_o | output | ADDR_W | Lane A address |
| out_b_valid_o | output | 1 | Lane B holds an instruction |
| out_b_insn_o | output | 15 | Lane B payload |
| out_b_addr_o | output | ADDR_W | Lane B address |
| illegal_pair_o | output | 1 | Parallel request broke the class rule |
| next_pc_o | output | ADDR_W | Address following the shown packet |

## Verification
The bench builds the block with a 12-bit address, a reset PC of 0x100 and a class map of 0x9C63E4B1, which gives all four classes to the sixteen class keys. This makes it possible to sweep every left and right key against both settings of the parallel bit. That sweep covers every legal and illegal pairing, with back-pressure applied on a share of the slots. Long slots, right-halfword entries with the marker bits set, and a redirect between the two halves of a pair complete the coverage.

// File: rtl/slot_pkg.sv
package slot_pkg;
  localparam int SLOT_W  = 32;
  localparam int HALF_W  = 16;
  localparam int SHORT_W = HALF_W - 1;
  localparam int LONG_W  = SLOT_W - 1;
  localparam int KEY_W   = 4;
  localparam int NKEY    = 1 << KEY_W;
  localparam int MAP_W   = 2 * NKEY;
  localparam int O_BIT   = 0;
  localparam int S_BIT   = 1;

  typedef enum logic [1:0] {
    MD_LONG,
    MD_HALF,
    MD_SEQ,
    MD_PAR
  } slot_mode_e;

  typedef logic [1:0] pipe_cls_t;
endpackage

// File: rtl/slot_splitter.sv
module slot_splitter
  import slot_pkg::*;
(
  input  logic [SLOT_W-1:0]  word_i,
  output logic               is_long_o,
  output logic               par_req_o,
  output logic [LONG_W-1:0]  long_o,
  output logic [SHORT_W-1:0] left_o,
  output logic [SHORT_W-1:0] right_o,
  output logic [KEY_W-1:0]   left_key_o,
  output logic [KEY_W-1:0]   right_key_o
);
  assign is_long_o   = word_i[SLOT_W-1];
  assign par_req_o   = word_i[HALF_W-1];
  assign long_o      = word_i[LONG_W-1:0];
  assign left_o      = word_i[SLOT_W-2:HALF_W];
  assign right_o     = word_i[SHORT_W-1:0];
  assign left_key_o  = left_o[SHORT_W-1 -: KEY_W];
  assign right_key_o = right_o[SHORT_W-1 -: KEY_W];
endmodule

// File: rtl/pipe_class_lut.sv
module pipe_class_lut
  import slot_pkg::*;
#(
  parameter logic [MAP_W-1:0] PIPE_MAP = 32'hE4E4_E4E4
) (
  input  logic [KEY_W-1:0] key_i,
  output pipe_cls_t        cls_o
);
  assign cls_o = PIPE_MAP[{key_i, 1'b0} +: 2];
endmodule

// File: rtl/pair_arbiter.sv
module pair_arbiter
  import slot_pkg::*;
#(
  parameter logic [MAP_W-1:0] PIPE_MAP = 32'hE4E4_E4E4
) (
  input  logic             half_entry_i,
  input  logic             is_long_i,
  input  logic             par_req_i,
  input  logic [KEY_W-1:0] left_key_i,
  input  logic [KEY_W-1:0] right_key_i,
  output slot_mode_e       mode_o,
  output logic             illegal_o
);
  logic [1:0][KEY_W-1:0] keys;
  pipe_cls_t [1:0]       cls;
  logic                  legal;

  assign keys[0] = left_key_i;
  assign keys[1] = right_key_i;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    pipe_class_lut #(.PIPE_MAP(PIPE_MAP)) i_lut (
      .key_i (keys[g]),
      .cls_o (cls[g])
    );
  end

  assign legal = cls[0][O_BIT] & cls[1][S_BIT];

  always_comb begin
    illegal_o = 1'b0;
    if (half_entry_i)                mode_o = MD_HALF;
    else if (is_long_i)              mode_o = MD_LONG;
    else if (par_req_i && legal)     mode_o = MD_PAR;
    else begin
      mode_o    = MD_SEQ;
      illegal_o = par_req_i;
    end
  end
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import slot_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] redirect_pc_i,
  input  logic              fetch_valid_i,
  input  logic [SLOT_W-1:0] fetch_data_i,
  input  logic              out_ready_i,
  input  slot_mode_e        mode_i,
  output logic              full_o,
  output logic [SLOT_W-1:0] word_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] step_pc_o
);
  localparam logic [ADDR_W-1:0] STEP_S = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_L = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] PC_INIT = {RESET_PC[ADDR_W-1:1], 1'b0};

  logic              full_q;
  logic [SLOT_W-1:0] word_q;
  logic [ADDR_W-1:0] pc_q;
  logic              fire;
  logic              unused_pc_lsb;

  assign unused_pc_lsb = redirect_pc_i[0];
  assign fire      = full_q & out_ready_i;
  assign step_pc_o = pc_q + ((mode_i == MD_LONG || mode_i == MD_PAR) ? STEP_L : STEP_S);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      word_q <= '0;
      pc_q   <= PC_INIT;
    end else if (redirect_i) begin
      full_q <= 1'b0;
      pc_q   <= {redirect_pc_i[ADDR_W-1:1], 1'b0};
    end else if (!full_q && fetch_valid_i) begin
      full_q <= 1'b1;
      word_q <= fetch_data_i;
    end else if (fire) begin
      pc_q   <= step_pc_o;
      // left half of a serial pair: keep the word, right half follows at pc+2
      full_q <= (mode_i == MD_SEQ);
    end
  end

  assign full_o = full_q;
  assign word_o = word_q;
  assign pc_o   = pc_q;
endmodule

// File: rtl/slot_frame_dec.sv
module slot_frame_dec
  import slot_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [MAP_W-1:0]  PIPE_MAP = 32'hE4E4_E4E4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                redirect_i,
  input  logic [ADDR_W-1:0]   redirect_pc_i,
  output logic [ADDR_W-1:0]   fetch_addr_o,
  output logic                fetch_ready_o,
  input  logic                fetch_valid_i,
  input  logic [SLOT_W-1:0]   fetch_data_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic                out_long_o,
  output logic                out_par_o,
  output logic [LONG_W-1:0]   out_a_insn_o,
  output logic [ADDR_W-1:0]   out_a_addr_o,
  output logic                out_b_valid_o,
  output logic [SHORT_W-1:0]  out_b_insn_o,
  output logic [ADDR_W-1:0]   out_b_addr_o,
  output logic                illegal_pair_o,
  output logic [ADDR_W-1:0]   next_pc_o
);
  localparam int PAD_W = LONG_W - SHORT_W;

  logic               full;
  logic [SLOT_W-1:0]  word;
  logic [ADDR_W-1:0]  pc;
  logic [ADDR_W-1:0]  step_pc;
  logic               is_long, par_req, illegal;
  logic [LONG_W-1:0]  long_pl;
  logic [SHORT_W-1:0] left_pl, right_pl;
  logic [KEY_W-1:0]   left_key, right_key;
  slot_mode_e         mode;

  slot_splitter i_split (
    .word_i      (word),
    .is_long_o   (is_long),
    .par_req_o   (par_req),
    .long_o      (long_pl),
    .left_o      (left_pl),
    .right_o     (right_pl),
    .left_key_o  (left_key),
    .right_key_o (right_key)
  );

  pair_arbiter #(.PIPE_MAP(PIPE_MAP)) i_arb (
    .half_entry_i (pc[1]),
    .is_long_i    (is_long),
    .par_req_i    (par_req),
    .left_key_i   (left_key),
    .right_key_i  (right_key),
    .mode_o       (mode),
    .illegal_o    (illegal)
  );

  slot_sequencer #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .redirect_i    (redirect_i),
    .redirect_pc_i (redirect_pc_i),
    .fetch_valid_i (fetch_valid_i),
    .fetch_data_i  (fetch_data_i),
    .out_ready_i   (out_ready_i),
    .mode_i        (mode),
    .full_o        (full),
    .word_o        (word),
    .pc_o          (pc),
    .step_pc_o     (step_pc)
  );

  always_comb begin
    unique case (mode)
      MD_LONG: out_a_insn_o = long_pl;
      MD_HALF: out_a_insn_o = {{PAD_W{1'b0}}, right_pl};
      default: out_a_insn_o = {{PAD_W{1'b0}}, left_pl};
    endcase
  end

  assign fetch_addr_o   = {pc[ADDR_W-1:2], 2'b00};
  assign fetch_ready_o  = ~full;
  assign out_valid_o    = full;
  assign out_long_o     = full & (mode == MD_LONG);
  assign out_par_o      = full & (mode == MD_PAR);
  assign out_b_valid_o  = full & (mode == MD_PAR);
  assign out_a_addr_o   = pc;
  assign out_b_insn_o   = right_pl;
  assign out_b_addr_o   = pc + ADDR_W'(2);
  assign illegal_pair_o = full & illegal;
  assign next_pc_o      = full ? step_pc : pc;
endmodule

// File: rtl/slot_frame_chk.sv
module slot_frame_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              redirect_i,
  input logic              fetch_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              out_long_o,
  input logic              out_par_o,
  input logic [30:0]       out_a_insn_o,
  input logic [ADDR_W-1:0] out_a_addr_o,
  input logic              out_b_valid_o,
  input logic [ADDR_W-1:0] out_b_addr_o,
  input logic              illegal_pair_o,
  input logic [ADDR_W-1:0] next_pc_o
);
  localparam logic [ADDR_W-1:0] TWO  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] FOUR = ADDR_W'(4);

  a_r2_long_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_long_o |-> !out_b_valid_o && !out_par_o && next_pc_o == out_a_addr_o + FOUR);

  a_r3_right_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !redirect_i && !out_long_o && !out_par_o && !out_a_addr_o[1]
    |=> out_valid_o && out_a_addr_o == $past(out_a_addr_o) + TWO);

  a_r4_par_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_par_o |-> out_b_valid_o && out_b_addr_o == out_a_addr_o + TWO && !illegal_pair_o);

  a_r6_illegal_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_pair_o |-> out_valid_o && !out_par_o && !out_long_o && !out_a_addr_o[1]);

  a_r7_half_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_a_addr_o[1] |-> !out_long_o && !out_par_o && !out_b_valid_o
    && next_pc_o == out_a_addr_o + TWO);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !redirect_i |=> out_valid_o && $stable(out_a_insn_o)
    && $stable(out_a_addr_o) && $stable(illegal_pair_o) && $stable(out_par_o));

  a_r9_redirect_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> !out_valid_o && fetch_ready_o);

  a_r11_no_fetch_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !fetch_ready_o);
endmodule

bind slot_frame_dec slot_frame_chk #(.ADDR_W(ADDR_W)) i_slot_frame_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .redirect_i     (redirect_i),
  .fetch_ready_o  (fetch_ready_o),
  .out_valid_o    (out_valid_o),
  .out_ready_i    (out_ready_i),
  .out_long_o     (out_long_o),
  .out_par_o      (out_par_o),
  .out_a_insn_o   (out_a_insn_o),
  .out_a_addr_o   (out_a_addr_o),
  .out_b_valid_o  (out_b_valid_o),
  .out_b_addr_o   (out_b_addr_o),
  .illegal_pair_o (illegal_pair_o),
  .next_pc_o      (next_pc_o)
);

// File: tb/test_slot_frame_dec.sv
module test_slot_frame_dec;
  localparam int          AW   = 12;
  localparam logic [11:0] RPC  = 12'h100;
  localparam logic [31:0] MAP  = 32'h9C63_E4B1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          redirect_i = 1'b0;
  logic [AW-1:0] redirect_pc_i = '0;
  logic [AW-1:0] fetch_addr_o;
  logic          fetch_ready_o;
  logic          fetch_valid_i = 1'b0;
  logic [31:0]   fetch_data_i = '0;
  logic          out_valid_o;
  logic          out_ready_i = 1'b0;
  logic          out_long_o, out_par_o, out_b_valid_o, illegal_pair_o;
  logic [30:0]   out_a_insn_o;
  logic [14:0]   out_b_insn_o;
  logic [AW-1:0] out_a_addr_o, out_b_addr_o, next_pc_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  slot_frame_dec #(.ADDR_W(AW), .RESET_PC(RPC), .PIPE_MAP(MAP)) i_slot_frame_dec (
    .clk_i(clk), .rst_ni(rst_ni), .redirect_i(redirect_i), .redirect_pc_i(redirect_pc_i),
    .fetch_addr_o(fetch_addr_o), .fetch_ready_o(fetch_ready_o),
    .fetch_valid_i(fetch_valid_i), .fetch_data_i(fetch_data_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_long_o(out_long_o),
    .out_par_o(out_par_o), .out_a_insn_o(out_a_insn_o), .out_a_addr_o(out_a_addr_o),
    .out_b_valid_o(out_b_valid_o), .out_b_insn_o(out_b_insn_o), .out_b_addr_o(out_b_addr_o),
    .illegal_pair_o(illegal_pair_o), .next_pc_o(next_pc_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic legal_pair(input logic [3:0] lk, input logic [3:0] rk);
    return MAP[2*lk] & MAP[2*rk+1];  // R5
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_pkt(input string req, input logic [30:0] a, input logic [AW-1:0] aaddr,
                            input logic lng, input logic par, input logic bv,
                            input logic [14:0] b, input logic ill, input logic [AW-1:0] nxt,
                            input int stall);
    for (int s = 0; s < stall; s++) begin
      chk("R8 held valid", out_valid_o, 1);
      chk("R8 held payload", out_a_insn_o, a);
      chk("R11 no fetch while held", fetch_ready_o, 0);
      step();
    end
    chk({req, " valid"}, out_valid_o, 1);
    chk({req, " a_insn"}, out_a_insn_o, a);
    chk({req, " a_addr"}, out_a_addr_o, aaddr);
    chk({req, " long"}, out_long_o, lng);
    chk({req, " par"}, out_par_o, par);
    chk({req, " b_valid"}, out_b_valid_o, bv);
    if (bv) begin
      chk({req, " b_insn"}, out_b_insn_o, b);
      chk({req, " b_addr"}, out_b_addr_o, aaddr + 12'd2);
    end
    chk("R6 illegal flag", illegal_pair_o, ill);
    chk("R10 next_pc", next_pc_o, nxt);
    out_ready_i = 1'b1;
    step();
    out_ready_i = 1'b0;
  endtask

  task automatic load_slot(input logic [AW-1:0] pc, input logic [31:0] w);
    redirect_i = 1'b1;
    redirect_pc_i = pc;
    step();
    redirect_i = 1'b0;
    chk("R9 empty after redirect", out_valid_o, 0);
    chk("R11 fetch ready", fetch_ready_o, 1);
    chk(pc[1] ? "R7 fetch addr" : "R11 fetch addr", fetch_addr_o, {pc[AW-1:2], 2'b00});
    fetch_valid_i = 1'b1;
    fetch_data_i  = w;
    step();
    fetch_valid_i = 1'b0;
  endtask

  task automatic run_slot(input logic [AW-1:0] pc, input logic [31:0] w, input int stall);
    logic [AW-1:0] endpc;
    load_slot(pc, w);
    if (pc[1]) begin
      expect_pkt("R7 half entry", {16'd0, w[14:0]}, pc, 0, 0, 0, '0, 0, pc + 12'd2, stall);
      endpc = pc + 12'd2;
    end else if (w[31]) begin
      expect_pkt("R2 long", w[30:0], pc, 1, 0, 0, '0, 0, pc + 12'd4, stall);
      endpc = pc + 12'd4;
    end else if (w[15] && legal_pair(w[30:27], w[14:11])) begin
      expect_pkt("R4 parallel", {16'd0, w[30:16]}, pc, 0, 1, 1, w[14:0], 0, pc + 12'd4, stall);
      endpc = pc + 12'd4;
    end else begin
      expect_pkt(w[15] ? "R6 left" : "R3 left", {16'd0, w[30:16]}, pc, 0, 0, 0, '0,
                 w[15], pc + 12'd2, stall);
      expect_pkt(w[15] ? "R6 right" : "R3 right", {16'd0, w[14:0]}, pc + 12'd2, 0, 0, 0, '0,
                 0, pc + 12'd4, stall);
      endpc = pc + 12'd4;
    end
    chk("R11 slot released", out_valid_o, 0);
    chk("R11 fetch ready again", fetch_ready_o, 1);
    chk("R2 next fetch addr", fetch_addr_o, endpc);
  endtask

  initial begin
    logic [31:0] w;
    @(negedge clk);
    chk("R1 reset valid", out_valid_o, 0);
    chk("R1 reset fetch ready", fetch_ready_o, 1);
    chk("R1 reset fetch addr", fetch_addr_o, RPC);
    rst_ni = 1'b1;
    step();
    chk("R1 idle after reset", out_valid_o, 0);

    // R3 R4 R5 R6: every key pair, both pair modes
    for (int lk = 0; lk < 16; lk++) begin
      for (int rk = 0; rk < 16; rk++) begin
        for (int pb = 0; pb < 2; pb++) begin
          int idx;
          idx = (lk * 16 + rk) * 2 + pb;
          w = {1'b0, 4'(lk), 11'(lk * 37 + rk * 5 + 1), 1'(pb), 4'(rk), 11'(rk * 53 + lk + pb)};
          run_slot(12'(idx * 4), w, (idx % 7 == 0) ? 2 : 0);
        end
      end
    end

    // R2 long slots
    for (int i = 0; i < 8; i++) begin
      w = 32'h8000_0000 | (32'(i) * 32'h1357_9BDF);
      run_slot(12'(12'h800 + i * 8), w, i % 3);
    end

    // R7 halfword entries, marker bits set or clear
    for (int i = 0; i < 8; i++) begin
      w = {1'(i), 15'(i * 977), 1'(i >> 1), 15'(i * 4099 + 3)};
      run_slot(12'(12'h902 + i * 16), w, i % 2);
    end

    // R9 redirect between halves of a serial pair
    w = {1'b0, 15'h1234, 1'b0, 15'h4321};
    load_slot(12'h400, w);
    expect_pkt("R3 left before redirect", {16'd0, w[30:16]}, 12'h400, 0, 0, 0, '0, 0,
               12'h402, 0);
    redirect_i = 1'b1;
    redirect_pc_i = 12'h52B;
    step();
    redirect_i = 1'b0;
    chk("R9 right half dropped", out_valid_o, 0);
    chk("R9 fetch ready", fetch_ready_o, 1);
    chk("R9 new fetch addr bit0 cleared", fetch_addr_o, 12'h528);
    chk("R9 next_pc when idle", next_pc_o, 12'h52A);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule